// File: doc/BRIEF.md
# Fractional Vector Multiply-Accumulate Unit

This unit runs signed 16x16 fractional arithmetic on eight independent lanes in parallel. Each lane keeps a private 48-bit accumulator. Every issued operation does three things in that lane: it forms the product of its two inputs, doubles the product, and writes the updated accumulator. It then returns a saturated 16-bit value taken from accumulator bits 47:16.

There are two arithmetic forms.

- The multiply form replaces the accumulator with the doubled product plus a rounding constant of half an output LSB (0x8000).
- The accumulate form adds the doubled product to the whole accumulator and does not round.

Each form comes in a signed-saturation flavour and an unsigned-saturation flavour. The unit accepts one operation per clock when `valid_i` is high. Results appear one cycle later, qualified by `valid_o`.

Top module: `frac_mac_vec`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every accumulator is zero, `res_o` is zero and `valid_o` is low.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R3: With `op_i` = 0 (signed multiply), a lane's accumulator becomes the 48-bit sign extension of 2*a*b + 0x8000. The lane's result is bits 31:16 of that value, so the high slice is all zeros or all ones and the result is never 0x8000.
- R4: With `op_i` = 0 and both inputs equal to 0x8000 (-32768), the result is 0x7FFF.
- R5: With `op_i` = 1 (unsigned multiply), the arithmetic is the same as R3. The result is 0x0000 when the product is negative and 0xFFFF when both inputs are 0x8000.
- R6: With `op_i` = 2 or 3 (accumulate), the accumulator becomes the old accumulator plus the 48-bit sign-extended doubled product, modulo 2^48. No rounding constant is added, and carries reach the high slice.
- R7: After `op_i` = 0 or 2, the result is bits 47:16 of the new accumulator, read as a signed 32-bit number, saturated to the range 0x8000..0x7FFF.
- R8: After `op_i` = 1 or 3, the result is that same 32-bit value mapped as follows: 0x0000 if it is negative, 0xFFFF if it is above 32767, and its low 16 bits otherwise.
- R9: While `valid_i` is low, no accumulator changes and `res_o` holds its previous value.
- R10: Lane k uses only bits 16k+15:16k of `a_i` and `b_i` and drives only bits 16k+15:16k of `res_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 2 | 0 signed multiply, 1 unsigned multiply, 2 signed accumulate, 3 unsigned accumulate |
| a_i | input | 128 | First operand, eight 16-bit lanes, lane 0 in bits 15:0 |
| b_i | input | 128 | Second operand, same lane layout |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Saturated results, same lane layout |

## Verification
The hardest conditions to reach from the ports are accumulator states far outside the 16-bit window: a carry rippling into the high slice, and bits 47:16 overflowing in either direction. Random operands almost never produce these.

The stimulus therefore builds them on purpose:

- It seeds with a multiply of -32768 by -32768 and then accumulates the same pair repeatedly, which pushes the value up by 2^31 per step.
- It repeats the pattern with -32768 by 32767 to drive the accumulator strongly negative.
- It runs both sequences under both saturation flavours.

After that, a long random mix of all four operations, with idle cycles in between, checks that accumulators hold and carry across operation types.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_MAC_S = 2'd2,
    OP_MAC_U = 2'd3
  } fm_op_e;
endpackage

// File: rtl/frac_mac_mul.sv
module frac_mac_mul #(
  parameter int W     = 16,
  parameter int ACC_W = 48
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [ACC_W-1:0] dbl_o
);
  localparam int PW  = 2 * W;
  localparam int EXT = ACC_W - PW - 1;

  logic signed [PW-1:0] prod;

  assign prod  = $signed(a_i) * $signed(b_i);
  // doubled product, sign-extended to accumulator width
  assign dbl_o = {{EXT{prod[PW-1]}}, prod, 1'b0};
endmodule

// File: rtl/frac_mac_sat.sv
module frac_mac_sat #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] v_i,
  input  logic           uns_i,
  output logic [W-1:0]   res_o
);
  localparam int VW = 2 * W;

  logic neg, pos_ovf, neg_ovf;

  assign neg     = v_i[VW-1];
  assign pos_ovf = !neg && (v_i[VW-2:W-1] != '0);
  assign neg_ovf = neg && (v_i[VW-2:W-1] != '1);

  always_comb begin
    if (uns_i) begin
      if (neg)          res_o = '0;
      else if (pos_ovf) res_o = '1;
      else              res_o = v_i[W-1:0];
    end else begin
      if (pos_ovf)      res_o = {1'b0, {(W-1){1'b1}}};
      else if (neg_ovf) res_o = {1'b1, {(W-1){1'b0}}};
      else              res_o = v_i[W-1:0];
    end
  end
endmodule

// File: rtl/frac_mac_lane.sv
module frac_mac_lane
  import frac_mac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int ACC_W = 3 * W;
  localparam logic [ACC_W-1:0] ROUND = ACC_W'(1) << (W - 1);

  fm_op_e op;
  logic [ACC_W-1:0] acc_q, acc_d, dbl, base;
  logic [W-1:0] res_d, res_q;

  assign op = fm_op_e'(op_i);

  frac_mac_mul #(.W(W), .ACC_W(ACC_W)) u_mul (
    .a_i   (a_i),
    .b_i   (b_i),
    .dbl_o (dbl)
  );

  // multiply replaces the accumulator with a rounded product; accumulate adds
  assign base  = op_i[1] ? acc_q : ROUND;
  assign acc_d = base + dbl;

  frac_mac_sat #(.W(W)) u_sat (
    .v_i   (acc_d[ACC_W-1:W]),
    .uns_i (op_i[0]),
    .res_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (valid_i) begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign res_o = res_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_q) && $stable(res_q)));

  assert_mul_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1]) |=> (acc_q[ACC_W-1:2*W] == '0 || acc_q[ACC_W-1:2*W] == '1));

  assert_mul_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL_S) |=> (res_q != {1'b1, {(W-1){1'b0}}}));

  assert_corner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL_S && a_i == {1'b1, {(W-1){1'b0}}} && b_i == {1'b1, {(W-1){1'b0}}})
    |=> (res_q == {1'b0, {(W-1){1'b1}}}));

  assert_mulu_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL_U && a_i != '0 && b_i != '0 && (a_i[W-1] != b_i[W-1]))
    |=> (res_q == '0));
endmodule

// File: rtl/frac_mac_vec.sv
module frac_mac_vec #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         op_i,
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  output logic               valid_o,
  output logic [LANES*W-1:0] res_o
);
  logic valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    frac_mac_lane #(.W(W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .op_i    (op_i),
      .a_i     (a_i[g*W +: W]),
      .b_i     (b_i[g*W +: W]),
      .res_o   (res_o[g*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;

  assert_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: tb/frac_mac_vec_bench.sv
`timescale 1ns/1ps
module frac_mac_vec_bench;
  localparam int LANES = 8;
  localparam int W = 16;
  localparam longint MASK48 = (64'sd1 <<< 48) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [LANES*W-1:0] a_i = '0, b_i = '0;
  logic valid_o;
  logic [LANES*W-1:0] res_o;

  int n_run = 0, n_fail = 0;
  longint m_acc [LANES];
  logic [15:0] m_res [LANES];
  logic m_valid;
  logic [15:0] ta [LANES];
  logic [15:0] tb [LANES];

  always #10 clk_i = ~clk_i;

  frac_mac_vec #(.LANES(LANES), .W(W)) u_frac_mac_vec (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .valid_o, .res_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_sat(input longint acc, input bit uns);
    longint s, v;
    s = acc;
    if (acc[47]) s = acc - (64'sd1 <<< 48);
    v = s >>> 16;
    if (uns) begin
      if (v < 0) return 16'h0000;
      if (v > 32767) return 16'hFFFF;
    end else begin
      if (v > 32767) return 16'h7FFF;
      if (v < -32768) return 16'h8000;
    end
    return v[15:0];
  endfunction

  // called at a falling edge: drive, update model, check at the next falling edge
  task automatic step(input string req, input bit v, input logic [1:0] op);
    valid_i = v;
    op_i = op;
    for (int k = 0; k < LANES; k++) begin
      a_i[k*W +: W] = ta[k];
      b_i[k*W +: W] = tb[k];
    end
    if (v) begin
      for (int k = 0; k < LANES; k++) begin
        longint p;
        p = 2 * longint'($signed(ta[k])) * longint'($signed(tb[k]));
        if (op[1]) m_acc[k] = (m_acc[k] + p) & MASK48;
        else       m_acc[k] = (p + 32768) & MASK48;
        m_res[k] = m_sat(m_acc[k], op[0]);
      end
    end
    m_valid = v;
    @(negedge clk_i);
    chk({req, " R2 valid"}, {15'd0, valid_o}, {15'd0, m_valid});
    for (int k = 0; k < LANES; k++)
      chk({req, " R10 lane"}, res_o[k*W +: W], m_res[k]);
  endtask

  task automatic fill(input logic [15:0] x, input logic [15:0] y);
    for (int k = 0; k < LANES; k++) begin ta[k] = x; tb[k] = y; end
  endtask

  task automatic rnd();
    for (int k = 0; k < LANES; k++) begin
      ta[k] = 16'($urandom);
      tb[k] = 16'($urandom);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) begin m_acc[k] = 0; m_res[k] = '0; end
    m_valid = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: outputs zero during reset
    chk("R1 valid in reset", {15'd0, valid_o}, 16'd0);
    for (int k = 0; k < LANES; k++) chk("R1 res in reset", res_o[k*W +: W], 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: accumulate 0*0 reveals zero accumulator
    fill(16'h0, 16'h0); step("R1 acc zero", 1, 2'd2);
    // R3: signed multiply, directed and random
    fill(16'h4000, 16'h4000); step("R3 mul", 1, 2'd0);
    fill(16'h8000, 16'h7FFF); step("R3 mul neg", 1, 2'd0);
    fill(16'hFFFF, 16'h0001); step("R3 mul small", 1, 2'd0);
    repeat (20) begin rnd(); step("R3 mul rnd", 1, 2'd0); end
    // R4: corner case
    fill(16'h8000, 16'h8000); step("R4 corner", 1, 2'd0);
    // R5: unsigned multiply
    fill(16'h8000, 16'h8000); step("R5 mulu corner", 1, 2'd1);
    fill(16'h1234, 16'hF000); step("R5 mulu neg", 1, 2'd1);
    fill(16'hFFFF, 16'h0001); step("R5 mulu tiny neg", 1, 2'd1);
    repeat (20) begin rnd(); step("R5 mulu rnd", 1, 2'd1); end
    // R6/R7: positive overflow growth through high slice
    fill(16'h8000, 16'h8000); step("R7 seed", 1, 2'd0);
    repeat (6) step("R6 R7 mac pos", 1, 2'd2);
    // R6/R8: same growth with unsigned clamp
    repeat (3) step("R6 R8 macu pos", 1, 2'd3);
    // negative drive
    fill(16'h8000, 16'h7FFF); step("R7 seed neg", 1, 2'd0);
    repeat (6) step("R6 R7 mac neg", 1, 2'd2);
    repeat (3) step("R6 R8 macu neg", 1, 2'd3);
    // R9: idle with garbage inputs, then prove acc unchanged
    repeat (5) begin rnd(); step("R9 idle", 0, 2'($urandom)); end
    fill(16'h0, 16'h0); step("R9 acc kept", 1, 2'd2);
    fill(16'h0, 16'h0); step("R9 acc kept u", 1, 2'd3);
    // mixed random traffic
    repeat (3000) begin
      rnd();
      if ($urandom_range(0, 3) == 0)
        for (int k = 0; k < LANES; k++) if ($urandom_range(0, 1) == 1) begin ta[k] = 16'h8000; tb[k] = 16'h8000; end
      step("R6 R8 R9 mix", ($urandom_range(0, 4) != 0), 2'($urandom));
    end
    valid_i = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule